// File: doc/BRIEF.md
# Strided Transposed Convolution Overlap-Add Engine

This block computes one row of a one-dimensional transposed convolution with a configurable stride. It does not insert zeros into the input and does not rewrite the kernel. Each accepted input sample is multiplied by every active kernel weight in parallel, one multiplier per kernel position. The resulting product vector is added into a sliding window of partial sums. The window holds the output positions that later inputs can still touch. After each input it moves forward by the stride, and the positions it leaves behind are final and are emitted.

The weights, the kernel size and the stride are loaded once with a single strobe and stay resident for any number of rows. A row may arrive as several tiles with idle gaps between them. The window acts as the carry store that joins each tile's overlapping tail onto the next tile, so tile boundaries have no effect on the result. An input flagged as last-of-row causes the remaining kernel-minus-stride tail sums to be drained. The window is then left cleared for the next row.

Top module: `tconv_ola_engine`

## Requirements
- R1: After a synchronous reset, no output lane is valid, `in_ready` is high and the partial-sum window is zero.
- R2: A one-cycle `wt_load` captures the flattened weights (weight j in bits j*8 +: 8, signed) together with the kernel size and stride. These stay in force for every later row until the next load.
- R3: Output position p of a row equals the exact sum of x[i]*w[j] over all i*S + j = p, with 8-bit signed operands and 24-bit two's-complement results. This is the same as convolving the zero-upsampled input with the kernel.
- R4: The input is accepted every cycle within a row, whatever the stride. `in_ready` falls only on the cycle after a last-of-row input is accepted and during the drain that follows.
- R5: Each accepted input produces exactly one output beat, two clock edges after acceptance. That beat carries exactly S valid lanes, which are the next S final positions.
- R6: Idle cycles between the tiles of a row do not change any output value.
- R7: After the last input's beat, the K-S tail positions are emitted in beats of min(4, remaining) lanes. The row therefore holds exactly (W-1)*S + K elements.
- R8: The stride is selectable at run time as 2, 3 or 4, and the kernel size as any value from S+1 to 9.
- R9: After a row drains, the window is clear, so the next row's values carry nothing from the previous row.
- R10: Valid lanes always fill from lane 0 upward with no gaps, and lane e holds the element that comes after lane e-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wt_load | input | 1 | Strobe that captures weights and configuration |
| wt_vec | input | 72 | Flattened signed kernel weights, position j at bits j*8 +: 8 |
| cfg_k | input | 4 | Kernel size K (S+1 to 9) |
| cfg_s | input | 3 | Stride S (2 to 4) |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Engine can accept a sample |
| in_data | input | 8 | Signed input sample |
| in_last | input | 1 | Marks the final sample of a row |
| out_lane_vld | output | 4 | Per-lane valid of the output beat, filled from lane 0 |
| out_data | output | 96 | Four 24-bit signed output lanes, lane e at bits e*24 +: 24 |

## Verification
The embedded assertions check on every cycle that:
- valid lanes fill from lane 0 with no gaps;
- each body beat is exactly the stride wide;
- no product reaches the window while it is draining;
- the window's upper entries stay clear;
- `in_ready` drops after a last-of-row input.

The numerical correctness of the overlap sums, the stitching across tile gaps, the exact row length and the reuse of the weights across rows can only be shown by the bench's scenarios. The bench compares every element against a zero-insertion reference for each stride and kernel size, for several row widths and tile patterns.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
   typedef enum logic {
      ST_RUN   = 1'b0,
      ST_DRAIN = 1'b1
   } acc_state_e;

   function automatic int unsigned min_u(input int unsigned a, input int unsigned b);
      return (a < b) ? a : b;
   endfunction
endpackage

// File: rtl/tconv_weight_bank.sv
module tconv_weight_bank #(
   parameter int KMAX = 9,
   parameter int SMAX = 4,
   parameter int DW   = 8,
   parameter int KBW  = $clog2(KMAX + 1),
   parameter int SBW  = $clog2(SMAX + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     load,
   input  logic [KMAX*DW-1:0]       wt_vec,
   input  logic [KBW-1:0]           cfg_k,
   input  logic [SBW-1:0]           cfg_s,
   output logic [KMAX-1:0][DW-1:0]  w_q,
   output logic [KBW-1:0]           k_q,
   output logic [SBW-1:0]           s_q
);
   for (genvar j = 0; j < KMAX; j++) begin : g_wreg
      always_ff @(posedge clk) begin
         if (rst)       w_q[j] <= '0;
         else if (load) w_q[j] <= wt_vec[j*DW +: DW];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         k_q <= KBW'(KMAX);
         s_q <= SBW'(2);
      end else if (load) begin
         k_q <= cfg_k;
         s_q <= cfg_s;
      end
   end

   // R8: only legal stride/kernel pairs may be loaded
   assert_legal_cfg_R8: assert property (@(posedge clk) disable iff (rst)
      load |-> (cfg_s >= SBW'(2) && cfg_s <= SBW'(SMAX) &&
                KBW'(cfg_s) < cfg_k && cfg_k <= KBW'(KMAX)));
endmodule

// File: rtl/tconv_mul_lanes.sv
module tconv_mul_lanes #(
   parameter int KMAX = 9,
   parameter int DW   = 8,
   parameter int AW   = 24,
   parameter int KBW  = $clog2(KMAX + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     take,
   input  logic [DW-1:0]            x,
   input  logic                     x_last,
   input  logic [KMAX-1:0][DW-1:0]  w_q,
   input  logic [KBW-1:0]           k_q,
   output logic                     p_vld,
   output logic                     p_last,
   output logic [KMAX-1:0][AW-1:0]  prod
);
   localparam int PW = 2 * DW;

   for (genvar j = 0; j < KMAX; j++) begin : g_lane
      logic signed [PW-1:0] mul;
      always_comb mul = $signed(x) * $signed(w_q[j]);

      always_ff @(posedge clk) begin
         if (rst)
            prod[j] <= '0;
         else if (take)
            prod[j] <= (KBW'(j) < k_q) ? {{(AW-PW){mul[PW-1]}}, mul} : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         p_vld  <= 1'b0;
         p_last <= 1'b0;
      end else begin
         p_vld  <= take;
         p_last <= take & x_last;
      end
   end
endmodule

// File: rtl/tconv_overlap_acc.sv
module tconv_overlap_acc
   import tconv_pkg::*;
#(
   parameter int KMAX = 9,
   parameter int SMAX = 4,
   parameter int AW   = 24,
   parameter int KBW  = $clog2(KMAX + 1),
   parameter int SBW  = $clog2(SMAX + 1)
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     p_vld,
   input  logic                     p_last,
   input  logic [KMAX-1:0][AW-1:0]  prod,
   input  logic [KBW-1:0]           k_q,
   input  logic [SBW-1:0]           s_q,
   output logic                     busy,
   output logic [SMAX-1:0]          out_lane_vld,
   output logic [SMAX*AW-1:0]       out_data
);
   typedef logic [KMAX-1:0][AW-1:0] win_t;

   acc_state_e     state;
   win_t           win;
   win_t           sum;
   logic [KBW-1:0] rem;
   logic [SBW-1:0] dr_n;
   logic           hi_clean;

   function automatic win_t slide(input win_t v, input logic [SBW-1:0] amt);
      win_t r;
      r = '0;
      for (int a = 1; a <= SMAX; a++)
         if (amt == SBW'(a))
            for (int j = 0; j < KMAX - a; j++)
               r[j] = v[j + a];
      return r;
   endfunction

   for (genvar j = 0; j < KMAX; j++) begin : g_sum
      assign sum[j] = win[j] + prod[j];
   end

   always_comb dr_n = (rem > KBW'(SMAX)) ? SBW'(SMAX) : SBW'(rem);

   assign busy = (state == ST_DRAIN);

   always_ff @(posedge clk) begin
      if (rst) begin
         state        <= ST_RUN;
         win          <= '0;
         rem          <= '0;
         out_lane_vld <= '0;
         out_data     <= '0;
      end else begin
         out_lane_vld <= '0;
         case (state)
            ST_RUN: begin
               if (p_vld) begin
                  for (int e = 0; e < SMAX; e++) begin
                     out_data[e*AW +: AW] <= sum[e];
                     out_lane_vld[e]      <= (SBW'(e) < s_q);
                  end
                  win <= slide(sum, s_q);
                  if (p_last) begin
                     state <= ST_DRAIN;
                     rem   <= k_q - KBW'(s_q);
                  end
               end
            end
            ST_DRAIN: begin
               for (int e = 0; e < SMAX; e++) begin
                  out_data[e*AW +: AW] <= win[e];
                  out_lane_vld[e]      <= (SBW'(e) < dr_n);
               end
               rem <= rem - KBW'(dr_n);
               if (rem <= KBW'(SMAX)) begin
                  state <= ST_RUN;
                  win   <= '0;
               end else begin
                  win <= slide(win, dr_n);
               end
            end
            default: state <= ST_RUN;
         endcase
      end
   end

   always_comb begin
      hi_clean = 1'b1;
      for (int j = 0; j < KMAX; j++)
         if ((j + 1) >= int'(k_q) && win[j] != '0) hi_clean = 1'b0;
   end

   // R10: lanes fill contiguously from lane 0
   assert_lane_order_R10: assert property (@(posedge clk) disable iff (rst)
      (out_lane_vld & SMAX'(out_lane_vld + 1'b1)) == '0);
   // R5: a body beat is exactly one stride wide
   assert_beat_width_R5: assert property (@(posedge clk) disable iff (rst)
      (state == ST_RUN && p_vld) |=> ($countones(out_lane_vld) == int'(s_q)));
   // R7: no new products arrive while the tail drains
   assert_no_input_in_drain_R7: assert property (@(posedge clk) disable iff (rst)
      (state == ST_DRAIN) |-> !p_vld);
   // R9: window entries beyond the live span stay clear
   assert_window_tail_clear_R9: assert property (@(posedge clk) disable iff (rst)
      hi_clean);
endmodule

// File: rtl/tconv_ola_engine.sv
module tconv_ola_engine #(
   parameter int KMAX = 9,
   parameter int SMAX = 4,
   parameter int DW   = 8,
   parameter int AW   = 24,
   parameter int KBW  = $clog2(KMAX + 1),
   parameter int SBW  = $clog2(SMAX + 1)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wt_load,
   input  logic [KMAX*DW-1:0]   wt_vec,
   input  logic [KBW-1:0]       cfg_k,
   input  logic [SBW-1:0]       cfg_s,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [DW-1:0]        in_data,
   input  logic                 in_last,
   output logic [SMAX-1:0]      out_lane_vld,
   output logic [SMAX*AW-1:0]   out_data
);
   localparam int GROWTH = $clog2((KMAX + 1) / 2 + 1);

   if (KMAX < 3) begin : g_bad_kmax
      $error("tconv_ola_engine: KMAX must be at least 3");
   end
   if (SMAX < 2 || SMAX >= KMAX) begin : g_bad_smax
      $error("tconv_ola_engine: SMAX must lie in [2, KMAX-1]");
   end
   if (AW < 2 * DW + GROWTH) begin : g_bad_aw
      $error("tconv_ola_engine: AW too narrow for exact sums");
   end

   logic [KMAX-1:0][DW-1:0] w_q;
   logic [KBW-1:0]          k_q;
   logic [SBW-1:0]          s_q;
   logic                    p_vld, p_last, busy, take;
   logic [KMAX-1:0][AW-1:0] prod;

   assign in_ready = !(p_vld && p_last) && !busy;
   assign take     = in_valid && in_ready;

   tconv_weight_bank #(.KMAX(KMAX), .SMAX(SMAX), .DW(DW), .KBW(KBW), .SBW(SBW)) u_bank (
      .clk(clk), .rst(rst), .load(wt_load), .wt_vec(wt_vec),
      .cfg_k(cfg_k), .cfg_s(cfg_s), .w_q(w_q), .k_q(k_q), .s_q(s_q));

   tconv_mul_lanes #(.KMAX(KMAX), .DW(DW), .AW(AW), .KBW(KBW)) u_mul (
      .clk(clk), .rst(rst), .take(take), .x(in_data), .x_last(in_last),
      .w_q(w_q), .k_q(k_q), .p_vld(p_vld), .p_last(p_last), .prod(prod));

   tconv_overlap_acc #(.KMAX(KMAX), .SMAX(SMAX), .AW(AW), .KBW(KBW), .SBW(SBW)) u_acc (
      .clk(clk), .rst(rst), .p_vld(p_vld), .p_last(p_last), .prod(prod),
      .k_q(k_q), .s_q(s_q), .busy(busy),
      .out_lane_vld(out_lane_vld), .out_data(out_data));

   // R1: reset leaves no valid lane and the input open
   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (out_lane_vld == '0 && in_ready));
   // R7: a last-of-row input closes the input for the drain
   assert_ready_drop_after_last_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_last) |=> !in_ready);
endmodule

// File: tb/sim_tconv_ola_engine.sv
module sim_tconv_ola_engine;
   localparam int KMAX = 9;
   localparam int SMAX = 4;
   localparam int DW   = 8;
   localparam int AW   = 24;

   logic                 clk = 1'b0;
   logic                 rst = 1'b1;
   logic                 wt_load = 1'b0;
   logic [KMAX*DW-1:0]   wt_vec = '0;
   logic [3:0]           cfg_k = 4'd3;
   logic [2:0]           cfg_s = 3'd2;
   logic                 in_valid = 1'b0;
   logic                 in_ready;
   logic [DW-1:0]        in_data = '0;
   logic                 in_last = 1'b0;
   logic [SMAX-1:0]      out_lane_vld;
   logic [SMAX*AW-1:0]   out_data;

   tconv_ola_engine u0 (
      .clk(clk), .rst(rst), .wt_load(wt_load), .wt_vec(wt_vec),
      .cfg_k(cfg_k), .cfg_s(cfg_s), .in_valid(in_valid), .in_ready(in_ready),
      .in_data(in_data), .in_last(in_last),
      .out_lane_vld(out_lane_vld), .out_data(out_data));

   always #5 clk = ~clk;

   int n_cmp = 0, n_bad = 0, cycles = 0;
   int cur_w = 0, cur_s = 2, cur_k = 3, exp_len = 0;
   int got_n = 0, beat_i = 0, body_ok = 0;
   int signed got [0:127];
   int signed xs   [0:31];
   int signed ws   [0:KMAX-1];
   int signed refv [0:127];

   task automatic chk(input string req, input longint act, input longint exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int exp_lanes();
      int rest;
      if (beat_i < cur_w) return cur_s;
      rest = exp_len - got_n;
      return (rest > SMAX) ? SMAX : rest;
   endfunction

   // Output monitor, sampled away from the active edge
   always @(negedge clk) begin
      if (!rst && out_lane_vld != '0) begin
         int cnt;
         cnt = $countones(out_lane_vld);
         chk("R10 lane fill", int'(out_lane_vld), (1 << cnt) - 1);
         chk(beat_i < cur_w ? "R5 body beat width" : "R7 drain beat width", cnt, exp_lanes());
         if (beat_i < cur_w && cnt == cur_s) body_ok++;
         for (int e = 0; e < SMAX; e++)
            if (out_lane_vld[e] && got_n < 128) begin
               got[got_n] = int'($signed(out_data[e*AW +: AW]));
               got_n++;
            end
         beat_i++;
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 150000) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic load_weights(input int k, input int s);
      @(negedge clk);
      for (int j = 0; j < KMAX; j++) begin
         ws[j] = (j < k) ? ((j == 0) ? -128 : int'($urandom_range(255)) - 128) : 0;
         wt_vec[j*DW +: DW] = DW'(ws[j]);
      end
      cfg_k = 4'(k);
      cfg_s = 3'(s);
      cur_k = k;
      cur_s = s;
      wt_load = 1'b1;
      @(negedge clk);
      wt_load = 1'b0;
   endtask

   // mode 0: back-to-back, 1: tiles of 4 with gaps, 2: back-to-back extreme values
   task automatic run_row(input int w, input int mode, input string tag);
      int stalls;
      exp_len = (w - 1) * cur_s + cur_k;
      for (int i = 0; i < w; i++)
         xs[i] = (mode == 2) ? ((i % 2 == 0) ? -128 : 127) : int'($urandom_range(255)) - 128;
      // zero-inserted reference: upsample then convolve
      for (int p = 0; p < exp_len; p++) begin
         refv[p] = 0;
         for (int j = 0; j < cur_k; j++)
            if (p - j >= 0 && (p - j) % cur_s == 0 && (p - j) / cur_s < w)
               refv[p] += xs[(p - j) / cur_s] * ws[j];
      end
      got_n = 0; beat_i = 0; body_ok = 0; cur_w = w; stalls = 0;
      for (int i = 0; i < w; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = DW'(xs[i]);
         in_last  = (i == w - 1);
         while (!in_ready) begin
            stalls++;
            @(negedge clk);
         end
         if (mode == 1 && i % 4 == 3 && i != w - 1) begin
            @(negedge clk);
            in_valid = 1'b0;
            repeat (2) @(negedge clk);
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      for (int t = 0; t < 40 && got_n < exp_len; t++) @(negedge clk);
      repeat (3) @(negedge clk);
      chk("R4 input stalls within row", stalls, 0);
      chk("R7 row length", got_n, exp_len);
      chk("R8 body beats of stride width", body_ok, w);
      chk("R9 input reopened after drain", int'(in_ready), 1);
      for (int p = 0; p < exp_len && p < got_n; p++)
         chk(tag, got[p], refv[p]);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 ready after reset", int'(in_ready), 1);
      chk("R1 lanes idle after reset", int'(out_lane_vld), 0);
      rst = 1'b0;
      @(negedge clk);
      chk("R1 lanes idle after release", int'(out_lane_vld), 0);
      // R1: cleared window gives exact first row (default zero weights -> zeros)
      cur_k = 9; cur_s = 2;
      for (int j = 0; j < KMAX; j++) ws[j] = 0;
      run_row(3, 0, "R1 zero weights after reset");
      for (int s = 2; s <= 4; s++)
         for (int k = s + 1; k <= KMAX; k++) begin
            load_weights(k, s);
            run_row(13, 0, "R3 element value");
            run_row(11, 1, "R6 tiled element value");
            run_row(1, 0, "R2 reused weights single input");
            run_row(6, 2, "R9 next row extreme values");
         end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule